// File: doc/BRIEF.md
# Bidirectional FIFO Port Access Decoder

This block sits between the two external ports of a dual-direction FIFO pair and the storage and flag logic behind them. Port A writes the first FIFO and reads the second; port B writes the second and reads the first. Each port has four control inputs: an active-low chip select, a direction select, an enable and a mailbox select. From these inputs and the ready and mailbox status flags, the block produces qualified write and read strobes for the FIFOs and the mailboxes, plus a bus output enable. It also keeps the write and read pointers of both FIFOs and the output register of each reading port.

The two ports read their direction select with opposite polarity. On port A a high level means write. On port B a low level means write. Each port runs on its own clock, and no activity on one port changes any output of the other. An access that a ready or mailbox flag refuses produces no strobe. Instead it raises a one-cycle overflow pulse for a write or an underflow pulse for a read. A master reset or a partial reset of one FIFO returns both of that FIFO's pointers to location zero and clears the output register fed by that FIFO. The master form must be held for at least four edges of each clock.

Top module: `bfifo_port_ctrl`

## Requirements
- R1: The port A bus output enable `a_oe` is high exactly when `a_cs_n`=0 and `a_wr`=0. The port B output enable `b_oe` is high exactly when `b_cs_n`=0 and `b_wr_n`=1. Neither depends on enable or reset.
- R2: `f1_wr_stb` is high exactly when all of these hold: `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mb`=0, `f1_in_rdy`=1, and FIFO1 is not in reset.
- R3: `f2_rd_stb` is high exactly when all of these hold: `a_cs_n`=0, `a_wr`=0, `a_en`=1, `a_mb`=0, `f2_out_rdy`=1, and FIFO2 is not in reset.
- R4: Port B reads `b_wr_n`=0 as write and `b_wr_n`=1 as read. `f2_wr_stb` needs `b_cs_n`=0, `b_en`=1, `b_mb`=0 and `f2_in_rdy`=1. `f1_rd_stb` needs `b_cs_n`=0, `b_en`=1, `b_mb`=0 and `f1_out_rdy`=1. Each strobe is blocked while its FIFO is in reset.
- R5: With the port's mailbox select at 1, the same chip select, direction and enable decode drives a mailbox strobe and no FIFO strobe. A mailbox write is allowed only while the target mailbox flag (`mb1_full` for A, `mb2_full` for B) is 0. A mailbox read is allowed only while the source flag (`mb2_full` for A, `mb1_full` for B) is 1.
- R6: A write attempt that is refused (FIFO not input-ready, or mailbox full) sets the port's overflow output high for exactly the next clock of that port. A refused read attempt (FIFO not output-ready, or mailbox empty) does the same on the underflow output. No pulse is raised while the FIFO concerned is in reset.
- R7: Each pointer advances by one on every clock where its strobe is high, wraps from DEPTH-1 to 0, and otherwise holds.
- R8: A port's output register loads the read data input on the clock edge of a FIFO read strobe and holds at all other times.
- R9: While a FIFO's master reset or partial reset input is high at a clock edge, that edge clears the FIFO's pointer in that clock domain to 0. It also clears the output register of the port that reads that FIFO.
- R10: Traffic or reset on one FIFO leaves the other FIFO's pointers and output register untouched, and port B activity changes no port A output.
- R11: A master reset is held high for at least four rising edges of each clock, after which both pointers of that FIFO read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| f1_mrst | input | 1 | FIFO1 master reset, active high |
| f1_prst | input | 1 | FIFO1 partial reset, active high |
| f2_mrst | input | 1 | FIFO2 master reset, active high |
| f2_prst | input | 1 | FIFO2 partial reset, active high |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_mb | input | 1 | Port A mailbox select |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr_n | input | 1 | Port B direction, 0 = write |
| b_en | input | 1 | Port B enable |
| b_mb | input | 1 | Port B mailbox select |
| f1_in_rdy | input | 1 | FIFO1 can accept a word |
| f1_out_rdy | input | 1 | FIFO1 has a word to read |
| f2_in_rdy | input | 1 | FIFO2 can accept a word |
| f2_out_rdy | input | 1 | FIFO2 has a word to read |
| mb1_full | input | 1 | A-to-B mailbox occupied |
| mb2_full | input | 1 | B-to-A mailbox occupied |
| f1_rd_data | input | DATA_W | FIFO1 word at its read pointer |
| f2_rd_data | input | DATA_W | FIFO2 word at its read pointer |
| a_oe | output | 1 | Port A bus drive enable |
| a_dout | output | DATA_W | Port A output register |
| b_oe | output | 1 | Port B bus drive enable |
| b_dout | output | DATA_W | Port B output register |
| f1_wr_stb | output | 1 | FIFO1 write strobe (clk_a) |
| f2_rd_stb | output | 1 | FIFO2 read strobe (clk_a) |
| mb1_wr_stb | output | 1 | Mailbox 1 write strobe (clk_a) |
| mb2_rd_stb | output | 1 | Mailbox 2 read strobe (clk_a) |
| f2_wr_stb | output | 1 | FIFO2 write strobe (clk_b) |
| f1_rd_stb | output | 1 | FIFO1 read strobe (clk_b) |
| mb2_wr_stb | output | 1 | Mailbox 2 write strobe (clk_b) |
| mb1_rd_stb | output | 1 | Mailbox 1 read strobe (clk_b) |
| f1_wr_ptr | output | PTR_W | FIFO1 write pointer |
| f1_rd_ptr | output | PTR_W | FIFO1 read pointer |
| f2_wr_ptr | output | PTR_W | FIFO2 write pointer |
| f2_rd_ptr | output | PTR_W | FIFO2 read pointer |
| a_ovf | output | 1 | Port A refused write pulse |
| a_udf | output | 1 | Port A refused read pulse |
| b_ovf | output | 1 | Port B refused write pulse |
| b_udf | output | 1 | Port B refused read pulse |

## Verification
The hardest case to reach is a clock where a port makes a fully qualified access in the same cycle that the target FIFO enters reset. In that cycle the strobe and the error pulse must both vanish, while the other port's pointer keeps moving. The stimulus produces this by raising master and partial resets at random points during dense, randomized two-port traffic. A directed master reset is also applied while port B is writing. A depth that is not a power of two makes the pointer wrap at the odd limit many times during the run. The mailbox refusal paths are forced directly by holding each mailbox flag against the access that it should block.

// File: rtl/bfd_pkg.sv
`timescale 1ns/1ps
package bfd_pkg;

  // level of the direction select that means "write" on a given port
  typedef enum logic {
    SEL_LOW_WRITES  = 1'b0,
    SEL_HIGH_WRITES = 1'b1
  } wr_level_e;

  // qualified strobes produced by one port decoder
  typedef struct packed {
    logic fifo_wr;
    logic fifo_rd;
    logic mbox_wr;
    logic mbox_rd;
  } port_stb_t;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/bfd_port_decode.sv
`timescale 1ns/1ps
module bfd_port_decode #(
  parameter bfd_pkg::wr_level_e WR_LEVEL = bfd_pkg::SEL_HIGH_WRITES
) (
  input  logic               clk,
  input  logic               wr_clr,     // reset of the FIFO this port writes
  input  logic               rd_clr,     // reset of the FIFO this port reads
  input  logic               cs_n,
  input  logic               wr_sel,
  input  logic               en,
  input  logic               mb_sel,
  input  logic               wr_ready,
  input  logic               rd_ready,
  input  logic               mbw_busy,   // outgoing mailbox occupied
  input  logic               mbr_valid,  // incoming mailbox occupied
  output logic               bus_oe,
  output bfd_pkg::port_stb_t stb,
  output logic               ovf,
  output logic               udf
);

  logic is_write;

  generate
    if (WR_LEVEL == bfd_pkg::SEL_HIGH_WRITES) begin : g_high_wr
      assign is_write = wr_sel;
    end else begin : g_low_wr
      assign is_write = ~wr_sel;
    end
  endgenerate

  logic access, want_wr, want_rd;
  logic wr_refused, rd_refused;

  assign access  = ~cs_n & en;
  assign want_wr = access &  is_write;
  assign want_rd = access & ~is_write;

  // bus is driven whenever the port is selected for reading
  assign bus_oe = ~cs_n & ~is_write;

  always_comb begin
    stb.fifo_wr = want_wr & ~mb_sel & wr_ready  & ~wr_clr;
    stb.mbox_wr = want_wr &  mb_sel & ~mbw_busy & ~wr_clr;
    stb.fifo_rd = want_rd & ~mb_sel & rd_ready  & ~rd_clr;
    stb.mbox_rd = want_rd &  mb_sel & mbr_valid & ~rd_clr;
  end

  assign wr_refused = want_wr & ~wr_clr & (mb_sel ? mbw_busy   : ~wr_ready);
  assign rd_refused = want_rd & ~rd_clr & (mb_sel ? ~mbr_valid : ~rd_ready);

  always_ff @(posedge clk) begin
    if (wr_clr) ovf <= 1'b0;
    else        ovf <= wr_refused;
  end

  always_ff @(posedge clk) begin
    if (rd_clr) udf <= 1'b0;
    else        udf <= rd_refused;
  end

  assert_wr_accept_no_ovf_R6: assert property (@(posedge clk) disable iff (wr_clr)
    (stb.fifo_wr || stb.mbox_wr) |=> !ovf);

  assert_rd_accept_no_udf_R6: assert property (@(posedge clk) disable iff (rd_clr)
    (stb.fifo_rd || stb.mbox_rd) |=> !udf);

  assert_oe_never_on_write_R1: assert property (@(posedge clk)
    bus_oe |-> !(stb.fifo_wr || stb.mbox_wr));

endmodule

// File: rtl/bfd_ring_ptr.sv
`timescale 1ns/1ps
module bfd_ring_ptr #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = bfd_pkg::ptr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (clr)
      ptr <= '0;
    else if (inc)
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  assert_ptr_cleared_R9: assert property (@(posedge clk)
    clr |=> (ptr == '0));

  assert_ptr_holds_R7: assert property (@(posedge clk) disable iff (clr)
    !inc |=> $stable(ptr));

  assert_ptr_moves_R7: assert property (@(posedge clk) disable iff (clr)
    inc |=> (ptr != $past(ptr)));

endmodule

// File: rtl/bfd_out_reg.sv
`timescale 1ns/1ps
module bfd_out_reg #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (clr)       dout <= '0;
    else if (load) dout <= din;
  end

  assert_dout_holds_R8: assert property (@(posedge clk) disable iff (clr)
    !load |=> $stable(dout));

  assert_dout_cleared_R9: assert property (@(posedge clk)
    clr |=> (dout == '0));

endmodule

// File: rtl/bfd_mrst_hold_chk.sv
`timescale 1ns/1ps
module bfd_mrst_hold_chk #(
  parameter int unsigned MIN_EDGES = 4
) (
  input logic clk,
  input logic lvl
);

  logic [MIN_EDGES-1:0] hist;

  always_ff @(posedge clk) begin
    hist <= {hist[MIN_EDGES-2:0], lvl};
  end

  assert_mrst_long_enough_R11: assert property (@(posedge clk)
    $fell(lvl) |-> (&hist));

endmodule

// File: rtl/bfifo_port_ctrl.sv
`timescale 1ns/1ps
module bfifo_port_ctrl #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned PTR_W = bfd_pkg::ptr_bits(DEPTH)
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              f1_mrst,
  input  logic              f1_prst,
  input  logic              f2_mrst,
  input  logic              f2_prst,
  input  logic              a_cs_n,
  input  logic              a_wr,
  input  logic              a_en,
  input  logic              a_mb,
  input  logic              b_cs_n,
  input  logic              b_wr_n,
  input  logic              b_en,
  input  logic              b_mb,
  input  logic              f1_in_rdy,
  input  logic              f1_out_rdy,
  input  logic              f2_in_rdy,
  input  logic              f2_out_rdy,
  input  logic              mb1_full,
  input  logic              mb2_full,
  input  logic [DATA_W-1:0] f1_rd_data,
  input  logic [DATA_W-1:0] f2_rd_data,
  output logic              a_oe,
  output logic [DATA_W-1:0] a_dout,
  output logic              b_oe,
  output logic [DATA_W-1:0] b_dout,
  output logic              f1_wr_stb,
  output logic              f2_rd_stb,
  output logic              mb1_wr_stb,
  output logic              mb2_rd_stb,
  output logic              f2_wr_stb,
  output logic              f1_rd_stb,
  output logic              mb2_wr_stb,
  output logic              mb1_rd_stb,
  output logic [PTR_W-1:0]  f1_wr_ptr,
  output logic [PTR_W-1:0]  f1_rd_ptr,
  output logic [PTR_W-1:0]  f2_wr_ptr,
  output logic [PTR_W-1:0]  f2_rd_ptr,
  output logic              a_ovf,
  output logic              a_udf,
  output logic              b_ovf,
  output logic              b_udf
);

  localparam int unsigned N_FIFO = 2;

  logic f1_clr, f2_clr;
  assign f1_clr = f1_mrst | f1_prst;
  assign f2_clr = f2_mrst | f2_prst;

  bfd_pkg::port_stb_t stb_a, stb_b;

  // port A: writes FIFO1, reads FIFO2, high select level = write
  bfd_port_decode #(.WR_LEVEL(bfd_pkg::SEL_HIGH_WRITES)) u_dec_a (
    .clk       (clk_a),
    .wr_clr    (f1_clr),
    .rd_clr    (f2_clr),
    .cs_n      (a_cs_n),
    .wr_sel    (a_wr),
    .en        (a_en),
    .mb_sel    (a_mb),
    .wr_ready  (f1_in_rdy),
    .rd_ready  (f2_out_rdy),
    .mbw_busy  (mb1_full),
    .mbr_valid (mb2_full),
    .bus_oe    (a_oe),
    .stb       (stb_a),
    .ovf       (a_ovf),
    .udf       (a_udf)
  );

  // port B: writes FIFO2, reads FIFO1, low select level = write
  bfd_port_decode #(.WR_LEVEL(bfd_pkg::SEL_LOW_WRITES)) u_dec_b (
    .clk       (clk_b),
    .wr_clr    (f2_clr),
    .rd_clr    (f1_clr),
    .cs_n      (b_cs_n),
    .wr_sel    (b_wr_n),
    .en        (b_en),
    .mb_sel    (b_mb),
    .wr_ready  (f2_in_rdy),
    .rd_ready  (f1_out_rdy),
    .mbw_busy  (mb2_full),
    .mbr_valid (mb1_full),
    .bus_oe    (b_oe),
    .stb       (stb_b),
    .ovf       (b_ovf),
    .udf       (b_udf)
  );

  assign f1_wr_stb  = stb_a.fifo_wr;
  assign f2_rd_stb  = stb_a.fifo_rd;
  assign mb1_wr_stb = stb_a.mbox_wr;
  assign mb2_rd_stb = stb_a.mbox_rd;
  assign f2_wr_stb  = stb_b.fifo_wr;
  assign f1_rd_stb  = stb_b.fifo_rd;
  assign mb2_wr_stb = stb_b.mbox_wr;
  assign mb1_rd_stb = stb_b.mbox_rd;

  bfd_ring_ptr #(.DEPTH(DEPTH)) u_f1_wptr (
    .clk (clk_a), .clr (f1_clr), .inc (stb_a.fifo_wr), .ptr (f1_wr_ptr)
  );
  bfd_ring_ptr #(.DEPTH(DEPTH)) u_f1_rptr (
    .clk (clk_b), .clr (f1_clr), .inc (stb_b.fifo_rd), .ptr (f1_rd_ptr)
  );
  bfd_ring_ptr #(.DEPTH(DEPTH)) u_f2_wptr (
    .clk (clk_b), .clr (f2_clr), .inc (stb_b.fifo_wr), .ptr (f2_wr_ptr)
  );
  bfd_ring_ptr #(.DEPTH(DEPTH)) u_f2_rptr (
    .clk (clk_a), .clr (f2_clr), .inc (stb_a.fifo_rd), .ptr (f2_rd_ptr)
  );

  bfd_out_reg #(.DATA_W(DATA_W)) u_a_oreg (
    .clk (clk_a), .clr (f2_clr), .load (stb_a.fifo_rd), .din (f2_rd_data), .dout (a_dout)
  );
  bfd_out_reg #(.DATA_W(DATA_W)) u_b_oreg (
    .clk (clk_b), .clr (f1_clr), .load (stb_b.fifo_rd), .din (f1_rd_data), .dout (b_dout)
  );

  // each master reset must span enough edges in both clock domains
  logic [N_FIFO-1:0] mrst_vec;
  assign mrst_vec = {f2_mrst, f1_mrst};

  generate
    for (genvar gi = 0; gi < N_FIFO; gi++) begin : g_mrst_chk
      bfd_mrst_hold_chk #(.MIN_EDGES(4)) u_hold_a (.clk (clk_a), .lvl (mrst_vec[gi]));
      bfd_mrst_hold_chk #(.MIN_EDGES(4)) u_hold_b (.clk (clk_b), .lvl (mrst_vec[gi]));
    end
  endgenerate

  // port A pointers are untouched unless port A itself strobes
  assert_a_wptr_isolated_R10: assert property (@(posedge clk_a) disable iff (f1_clr)
    !f1_wr_stb |=> $stable(f1_wr_ptr));

  assert_a_dout_isolated_R10: assert property (@(posedge clk_a) disable iff (f2_clr)
    !f2_rd_stb |=> $stable(a_dout));

endmodule

// File: tb/bfifo_port_ctrl_bench.sv
`timescale 1ns/1ps
module bfifo_port_ctrl_bench;

  localparam int unsigned DW    = 36;
  localparam int unsigned DEPTH = 12;
  localparam int unsigned AW    = bfd_pkg::ptr_bits(DEPTH);

  logic clk_a = 1'b0, clk_b = 1'b0;
  always #2.5 clk_a = ~clk_a;
  always #2.5 clk_b = ~clk_b;

  logic f1_mrst = 1, f1_prst = 0, f2_mrst = 1, f2_prst = 0;
  logic a_cs_n = 1, a_wr = 0, a_en = 0, a_mb = 0;
  logic b_cs_n = 1, b_wr_n = 1, b_en = 0, b_mb = 0;
  logic f1_in_rdy = 0, f1_out_rdy = 0, f2_in_rdy = 0, f2_out_rdy = 0;
  logic mb1_full = 0, mb2_full = 0;
  logic [DW-1:0] f1_rd_data = '0, f2_rd_data = '0;

  logic a_oe, b_oe;
  logic [DW-1:0] a_dout, b_dout;
  logic f1_wr_stb, f2_rd_stb, mb1_wr_stb, mb2_rd_stb;
  logic f2_wr_stb, f1_rd_stb, mb2_wr_stb, mb1_rd_stb;
  logic [AW-1:0] f1_wr_ptr, f1_rd_ptr, f2_wr_ptr, f2_rd_ptr;
  logic a_ovf, a_udf, b_ovf, b_udf;

  bfifo_port_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) u_bfifo_port_ctrl (.*);

  int checks = 0, errors = 0;

  // reference state
  int unsigned m_wp1 = 0, m_rp1 = 0, m_wp2 = 0, m_rp2 = 0;
  logic [DW-1:0] m_adout = '0, m_bdout = '0;
  bit m_aovf = 0, m_audf = 0, m_bovf = 0, m_budf = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int unsigned nxt(input int unsigned p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  // one clock: inputs already driven after a falling edge
  task automatic cycle();
    bit r1, r2, as, bs, aw, bw;
    bit e_f1w, e_f2r, e_m1w, e_m2r, e_f2w, e_f1r, e_m2w, e_m1r;
    #1;
    r1 = f1_mrst | f1_prst;
    r2 = f2_mrst | f2_prst;
    as = !a_cs_n && a_en;  aw = (a_wr == 1'b1);
    bs = !b_cs_n && b_en;  bw = (b_wr_n == 1'b0);
    e_f1w = as && aw  && !a_mb && f1_in_rdy  && !r1;
    e_m1w = as && aw  &&  a_mb && !mb1_full  && !r1;
    e_f2r = as && !aw && !a_mb && f2_out_rdy && !r2;
    e_m2r = as && !aw &&  a_mb && mb2_full   && !r2;
    e_f2w = bs && bw  && !b_mb && f2_in_rdy  && !r2;
    e_m2w = bs && bw  &&  b_mb && !mb2_full  && !r2;
    e_f1r = bs && !bw && !b_mb && f1_out_rdy && !r1;
    e_m1r = bs && !bw &&  b_mb && mb1_full   && !r1;
    chk("R1 a_oe", a_oe, (!a_cs_n && !aw));
    chk("R1 b_oe", b_oe, (!b_cs_n && !bw));
    chk("R2 f1_wr_stb", f1_wr_stb, e_f1w);
    chk("R3 f2_rd_stb", f2_rd_stb, e_f2r);
    chk("R4 f2_wr_stb", f2_wr_stb, e_f2w);
    chk("R4 f1_rd_stb", f1_rd_stb, e_f1r);
    chk("R5 mb1_wr_stb", mb1_wr_stb, e_m1w);
    chk("R5 mb2_rd_stb", mb2_rd_stb, e_m2r);
    chk("R5 mb2_wr_stb", mb2_wr_stb, e_m2w);
    chk("R5 mb1_rd_stb", mb1_rd_stb, e_m1r);
    // next state of the reference
    if (r1) begin m_wp1 = 0; m_rp1 = 0; m_bdout = '0; m_aovf = 0; m_budf = 0; end
    else begin
      if (e_f1w) m_wp1 = nxt(m_wp1);
      if (e_f1r) begin m_rp1 = nxt(m_rp1); m_bdout = f1_rd_data; end
      m_aovf = as && aw && (a_mb ? mb1_full : !f1_in_rdy);
      m_budf = bs && !bw && (b_mb ? !mb1_full : !f1_out_rdy);
    end
    if (r2) begin m_wp2 = 0; m_rp2 = 0; m_adout = '0; m_bovf = 0; m_audf = 0; end
    else begin
      if (e_f2w) m_wp2 = nxt(m_wp2);
      if (e_f2r) begin m_rp2 = nxt(m_rp2); m_adout = f2_rd_data; end
      m_bovf = bs && bw && (b_mb ? mb2_full : !f2_in_rdy);
      m_audf = as && !aw && (a_mb ? !mb2_full : !f2_out_rdy);
    end
    @(posedge clk_a);
    @(negedge clk_a);
    chk("R7 f1_wr_ptr", f1_wr_ptr, m_wp1);
    chk("R7 f1_rd_ptr", f1_rd_ptr, m_rp1);
    chk("R7 f2_wr_ptr", f2_wr_ptr, m_wp2);
    chk("R7 f2_rd_ptr", f2_rd_ptr, m_rp2);
    chk("R8 a_dout", a_dout, m_adout);
    chk("R8 b_dout", b_dout, m_bdout);
    chk("R6 a_ovf", a_ovf, m_aovf);
    chk("R6 a_udf", a_udf, m_audf);
    chk("R6 b_ovf", b_ovf, m_bovf);
    chk("R6 b_udf", b_udf, m_budf);
  endtask

  task automatic idle();
    a_cs_n = 1; a_en = 0; a_mb = 0; b_cs_n = 1; b_en = 0; b_mb = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk_a);
    // R11 / R9: master reset both FIFOs for six edges
    for (int i = 0; i < 6; i++) cycle();
    chk("R9 reset a_dout zero", a_dout, '0);
    chk("R9 reset b_dout zero", b_dout, '0);
    f1_mrst = 0; f2_mrst = 0;
    f1_in_rdy = 1; f1_out_rdy = 1; f2_in_rdy = 1; f2_out_rdy = 1;

    // R7: fourteen writes to FIFO1 wrap at depth 12
    a_cs_n = 0; a_wr = 1; a_en = 1; a_mb = 0;
    for (int i = 0; i < 14; i++) cycle();
    chk("R7 wrap f1_wr_ptr", f1_wr_ptr, 2);
    idle();

    // R8 / R4: port B reads FIFO1 three times
    b_cs_n = 0; b_wr_n = 1; b_en = 1;
    for (int i = 0; i < 3; i++) begin
      f1_rd_data = DW'(36'h0A5A5_0000 + i);
      cycle();
    end
    chk("R8 b_dout last word", b_dout, 36'h0A5A5_0002);

    // R10: port B writes FIFO2 while port A idle
    b_wr_n = 0;
    for (int i = 0; i < 5; i++) cycle();
    chk("R10 f1_wr_ptr untouched", f1_wr_ptr, 2);
    chk("R10 f2_wr_ptr moved", f2_wr_ptr, 5);
    idle();

    // R5 / R6: mailbox write refused when full, accepted when empty
    a_cs_n = 0; a_wr = 1; a_en = 1; a_mb = 1; mb1_full = 1;
    cycle();
    chk("R6 mailbox refusal a_ovf", a_ovf, 1);
    mb1_full = 0;
    cycle();
    chk("R5 mailbox accept a_ovf", a_ovf, 0);
    // R6: FIFO2 read refused when not output-ready
    a_wr = 0; a_mb = 0; f2_out_rdy = 0;
    cycle();
    chk("R6 refused read a_udf", a_udf, 1);
    f2_out_rdy = 1;
    idle();

    // R11 / R10: master reset FIFO1 for four edges while B writes FIFO2
    b_cs_n = 0; b_wr_n = 0; b_en = 1; f1_mrst = 1;
    for (int i = 0; i < 4; i++) cycle();
    f1_mrst = 0;
    chk("R11 f1_wr_ptr after mrst", f1_wr_ptr, 0);
    chk("R11 f1_rd_ptr after mrst", f1_rd_ptr, 0);
    chk("R10 f2_wr_ptr kept moving", f2_wr_ptr, 9);
    idle();

    // randomized two-port traffic with occasional resets
    begin
      int m1 = 0, m2 = 0;
      for (int n = 0; n < 4000; n++) begin
        a_cs_n = ($urandom % 5 == 0); a_wr = $urandom; a_en = ($urandom % 6 != 0);
        a_mb = ($urandom % 4 == 0);
        b_cs_n = ($urandom % 5 == 0); b_wr_n = $urandom; b_en = ($urandom % 6 != 0);
        b_mb = ($urandom % 4 == 0);
        f1_in_rdy = ($urandom % 4 != 0); f1_out_rdy = ($urandom % 4 != 0);
        f2_in_rdy = ($urandom % 4 != 0); f2_out_rdy = ($urandom % 4 != 0);
        mb1_full = $urandom; mb2_full = $urandom;
        f1_rd_data = DW'({$urandom, $urandom});
        f2_rd_data = DW'({$urandom, $urandom});
        if (m1 == 0 && $urandom % 200 == 0) m1 = 5;
        if (m2 == 0 && $urandom % 200 == 0) m2 = 5;
        f1_mrst = (m1 > 0); f2_mrst = (m2 > 0);
        if (m1 > 0) m1--;
        if (m2 > 0) m2--;
        f1_prst = ($urandom % 70 == 0);
        f2_prst = ($urandom % 70 == 0);
        cycle();
      end
      // finish any master reset in progress with a legal hold length
      f1_mrst = 1; f2_mrst = 1; f1_prst = 0; f2_prst = 0; idle();
      for (int i = 0; i < 5; i++) cycle();
      f1_mrst = 0; f2_mrst = 0;
      cycle();
      chk("R9 final f2_rd_ptr", f2_rd_ptr, 0);
    end

    summary();
  end

endmodule